// File: doc/BRIEF.md
# Wide Unsigned Multiply-Add Unit with Dual Register Write-Back

This execution unit serves big-integer arithmetic. It multiplies two 64-bit unsigned source values and keeps the full 128-bit product. It then adds a third 64-bit value, zero-extended, to that product. The 128-bit result is split into two halves. The low half goes to the destination named in the instruction, and the high half goes to a second destination that the instruction word does not name.

The unit also decodes the 32-bit instruction word. It extracts the destination and source register fields and checks both opcode fields against the configured encoding. It then derives the number of the implicit second destination. When the mode input is one, that number is the third source register. When the mode input is zero, it is the first destination plus a maximum vector length, taken modulo the 128-entry register file.

Operands enter through a valid/ready handshake and pass through a three-stage pipeline that stalls as a whole. Both register numbers and both data halves leave together under a single valid.

Top module: `wide_muladd_unit`

## Requirements
- R1: Instruction fields are taken MSB-first from the 32-bit word as follows: primary opcode = word[31:26], destination T = word[25:21], third source C = word[10:6], extended opcode = word[5:0]. Register numbers are zero-extended to 7 bits.
- R2: `res_rt_data` carries bits 63..0 of the unsigned sum in_a*in_b + in_c, where the product is formed at its full 128-bit width, and `res_rt_num` equals the decoded T field.
- R3: `res_rs_data` carries bits 127..64 of the same sum. The sum never overflows 128 bits, so an all-ones high half always comes with a zero low half.
- R4: in_c is zero-extended and added to the product at bit 0, so carries out of the low half reach the high half.
- R5: When `in_rs_from_rc` is 0, `res_rs_num` = (T + in_maxvl) mod 128.
- R6: When `in_rs_from_rc` is 1, `res_rs_num` equals the decoded C field.
- R7: When the primary or the extended opcode differs from PRIMARY_OP or EXT_OP, the result is presented with `res_illegal`=1, `res_wr_en`=0 and both data outputs zero. A legal op presents `res_wr_en`=1.
- R8: A result becomes valid right after the third rising edge, counting the edge that accepts the operands, provided the output is not stalled.
- R9: While `res_valid` is 1 and `res_ready` is 0, `in_ready` is 0 and every result output holds its value.
- R10: After reset, `res_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_insn | input | 32 | Instruction word |
| in_rs_from_rc | input | 1 | Implicit destination mode: 1 selects C, 0 selects T+maxvl |
| in_maxvl | input | 7 | Maximum vector length used as the register offset |
| in_a | input | 64 | Multiplicand |
| in_b | input | 64 | Multiplier |
| in_c | input | 64 | Addend |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer accepts the result |
| res_illegal | output | 1 | Opcode mismatch |
| res_wr_en | output | 1 | Both write-backs are to be performed |
| res_rt_num | output | 7 | Register number for the low half |
| res_rt_data | output | 64 | Low half of the sum |
| res_rs_num | output | 7 | Register number for the high half |
| res_rs_data | output | 64 | High half of the sum |

## Verification
A corrupted partial product or a wrong shift weight in the sum shows up in the data halves of the very result that passes through. An operand pattern that carries across the 64-bit boundary exposes such a fault in the same cycle the result turns valid. A fault in the register-number arithmetic, such as a lost wrap at 128 or a swapped mode, appears in `res_rs_num` for the result it affects. A fault in the stall logic shows within one cycle of holding `res_ready` low, either as a moving output or as `in_ready` staying high.

// File: rtl/muladd_pkg.sv
// Shared constants and types for the wide multiply-add unit.
// Assumes a 32-bit instruction word and a 128-entry register file.
package muladd_pkg;
    localparam int INSN_W  = 32;
    localparam int REGW    = 7;
    localparam int FIELD_W = 5;
    localparam int OPC_W   = 6;

    // Instruction word, first member at the most significant bits.
    typedef struct packed {
        logic [OPC_W-1:0]   po;
        logic [FIELD_W-1:0] rt;
        logic [FIELD_W-1:0] ra;
        logic [FIELD_W-1:0] rb;
        logic [FIELD_W-1:0] rc;
        logic [OPC_W-1:0]   xo;
    } insn_t;

    // Control information that travels alongside the data.
    typedef struct packed {
        logic            illegal;
        logic [REGW-1:0] rt_num;
        logic [REGW-1:0] rs_num;
    } tag_t;
endpackage

// File: rtl/muladd_decode.sv
// Combinational decode: checks the opcodes and derives both destination numbers.
// Assumes register numbers wrap modulo 2**REGW.
module muladd_decode
    import muladd_pkg::*;
#(
    parameter logic [OPC_W-1:0] PRIMARY_OP = 6'd4,
    parameter logic [OPC_W-1:0] EXT_OP     = 6'd48
) (
    input  logic [INSN_W-1:0] insn_word,
    input  logic              rs_from_rc,
    input  logic [REGW-1:0]   maxvl,
    output tag_t              tag
);
    insn_t           f;
    logic [REGW-1:0] rt_ext;
    logic [REGW-1:0] rc_ext;

    // Split the word and compute the register numbers.
    always_comb begin
        f           = insn_t'(insn_word);
        rt_ext      = REGW'(f.rt);
        rc_ext      = REGW'(f.rc);
        tag.illegal = (f.po != PRIMARY_OP) || (f.xo != EXT_OP);
        tag.rt_num  = rt_ext;
        tag.rs_num  = rs_from_rc ? rc_ext : REGW'(rt_ext + maxvl);
    end
endmodule

// File: rtl/muladd_pp_stage.sv
// Stage 2: forms the four half-width partial products and registers them.
// Assumes XLEN is even. All registers hold when en is low.
module muladd_pp_stage
    import muladd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   v_in,
    input  tag_t                   tag_in,
    input  logic [XLEN-1:0]        a,
    input  logic [XLEN-1:0]        b,
    input  logic [XLEN-1:0]        c,
    output logic                   v_out,
    output tag_t                   tag_out,
    output logic [3:0][XLEN-1:0]   pp,
    output logic [XLEN-1:0]        c_out
);
    localparam int H = XLEN / 2;

    // Move the control fields and the addend along the pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_out   <= 1'b0;
            tag_out <= '0;
            c_out   <= '0;
        end else if (en) begin
            v_out   <= v_in;
            tag_out <= tag_in;
            c_out   <= c;
        end
    end

    // One multiplier per pair of halves; index = 2*i + j.
    for (genvar i = 0; i < 2; i++) begin : g_ahalf
        for (genvar j = 0; j < 2; j++) begin : g_bhalf
            // Register the product a_half[i] * b_half[j].
            always_ff @(posedge clk) begin
                if (!rst_n) pp[2*i+j] <= '0;
                else if (en) pp[2*i+j] <= XLEN'(a[i*H +: H]) * XLEN'(b[j*H +: H]);
            end
        end
    end
endmodule

// File: rtl/muladd_sum_stage.sv
// Stage 3: adds the weighted partial products and the addend, then registers the outputs.
// Assumes the partial products come from muladd_pp_stage. An illegal op gives zero data.
module muladd_sum_stage
    import muladd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 v_in,
    input  tag_t                 tag_in,
    input  logic [3:0][XLEN-1:0] pp,
    input  logic [XLEN-1:0]      c,
    output logic                 res_valid,
    output logic                 res_illegal,
    output logic                 res_wr_en,
    output logic [REGW-1:0]      res_rt_num,
    output logic [XLEN-1:0]      res_rt_data,
    output logic [REGW-1:0]      res_rs_num,
    output logic [XLEN-1:0]      res_rs_data
);
    localparam int H = XLEN / 2;
    localparam int W = 2 * XLEN;

    logic [W-1:0] sum;

    // Weight each partial product by its half positions and add the addend at bit 0.
    always_comb begin
        sum = W'(c);
        for (int k = 0; k < 4; k++) begin
            sum = sum + (W'(pp[k]) << ((k / 2 + k % 2) * H));
        end
    end

    // Output register; it holds while en is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_illegal <= 1'b0;
            res_wr_en   <= 1'b0;
            res_rt_num  <= '0;
            res_rs_num  <= '0;
            res_rt_data <= '0;
            res_rs_data <= '0;
        end else if (en) begin
            res_valid   <= v_in;
            res_illegal <= v_in && tag_in.illegal;
            res_wr_en   <= v_in && !tag_in.illegal;
            res_rt_num  <= tag_in.rt_num;
            res_rs_num  <= tag_in.rs_num;
            res_rt_data <= tag_in.illegal ? '0 : sum[XLEN-1:0];
            res_rs_data <= tag_in.illegal ? '0 : sum[W-1:XLEN];
        end
    end
endmodule

// File: rtl/wide_muladd_unit.sv
// Top: a three-stage unsigned multiply-add with two register write-backs.
// Assumes a single-issue consumer. The whole pipe stalls while the result is not taken.
module wide_muladd_unit
    import muladd_pkg::*;
#(
    parameter int               XLEN       = 64,
    parameter logic [OPC_W-1:0] PRIMARY_OP = 6'd4,
    parameter logic [OPC_W-1:0] EXT_OP     = 6'd48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INSN_W-1:0] in_insn,
    input  logic              in_rs_from_rc,
    input  logic [REGW-1:0]   in_maxvl,
    input  logic [XLEN-1:0]   in_a,
    input  logic [XLEN-1:0]   in_b,
    input  logic [XLEN-1:0]   in_c,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_illegal,
    output logic              res_wr_en,
    output logic [REGW-1:0]   res_rt_num,
    output logic [XLEN-1:0]   res_rt_data,
    output logic [REGW-1:0]   res_rs_num,
    output logic [XLEN-1:0]   res_rs_data
);
    logic                 advance;
    tag_t                 dec_tag;
    logic                 s1_v;
    tag_t                 s1_tag;
    logic [XLEN-1:0]      s1_a, s1_b, s1_c;
    logic                 s2_v;
    tag_t                 s2_tag;
    logic [3:0][XLEN-1:0] s2_pp;
    logic [XLEN-1:0]      s2_c;

    // The pipe moves whenever the output slot is free or is being taken.
    always_comb begin
        advance  = !res_valid || res_ready;
        in_ready = advance;
    end

    muladd_decode #(.PRIMARY_OP(PRIMARY_OP), .EXT_OP(EXT_OP)) u_dec (
        .insn_word (in_insn),
        .rs_from_rc(in_rs_from_rc),
        .maxvl     (in_maxvl),
        .tag       (dec_tag)
    );

    // Stage 1: capture the operands. An illegal op captures zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_tag <= '0;
            s1_a   <= '0;
            s1_b   <= '0;
            s1_c   <= '0;
        end else if (advance) begin
            s1_v   <= in_valid;
            s1_tag <= dec_tag;
            s1_a   <= dec_tag.illegal ? '0 : in_a;
            s1_b   <= dec_tag.illegal ? '0 : in_b;
            s1_c   <= dec_tag.illegal ? '0 : in_c;
        end
    end

    muladd_pp_stage #(.XLEN(XLEN)) u_pp (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (advance),
        .v_in   (s1_v),
        .tag_in (s1_tag),
        .a      (s1_a),
        .b      (s1_b),
        .c      (s1_c),
        .v_out  (s2_v),
        .tag_out(s2_tag),
        .pp     (s2_pp),
        .c_out  (s2_c)
    );

    muladd_sum_stage #(.XLEN(XLEN)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (advance),
        .v_in       (s2_v),
        .tag_in     (s2_tag),
        .pp         (s2_pp),
        .c          (s2_c),
        .res_valid  (res_valid),
        .res_illegal(res_illegal),
        .res_wr_en  (res_wr_en),
        .res_rt_num (res_rt_num),
        .res_rt_data(res_rt_data),
        .res_rs_num (res_rs_num),
        .res_rs_data(res_rs_data)
    );
endmodule

// File: rtl/muladd_checker.sv
// Port-level properties of wide_muladd_unit, attached with bind.
// Assumes a synchronous active-low reset. Counts operations in flight to bound the pipe depth.
module muladd_checker
    import muladd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            res_valid,
    input logic            res_ready,
    input logic            res_illegal,
    input logic            res_wr_en,
    input logic [REGW-1:0] res_rt_num,
    input logic [XLEN-1:0] res_rt_data,
    input logic [REGW-1:0] res_rs_num,
    input logic [XLEN-1:0] res_rs_data
);
    logic [2:0] occ;

    // Track operations accepted but not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else occ <= occ + 3'(in_valid && in_ready) - 3'(res_valid && res_ready);
    end

    assert_reset_R10: assert property (@(posedge clk) !rst_n |=> !res_valid);

    assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_illegal |-> !res_wr_en && res_rt_data == '0 && res_rs_data == '0);

    assert_write_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr_en |-> res_valid && !res_illegal);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_illegal && (&res_rs_data) |-> res_rt_data == '0);

    assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |-> !in_ready);

    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_rt_data) && $stable(res_rs_data)
            && $stable(res_rt_num) && $stable(res_rs_num) && $stable(res_illegal));

    assert_depth_R8: assert property (@(posedge clk) disable iff (!rst_n) occ <= 3'd3);

    assert_valid_has_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> occ != 3'd0);
endmodule

bind wide_muladd_unit muladd_checker #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_illegal(res_illegal),
    .res_wr_en  (res_wr_en),
    .res_rt_num (res_rt_num),
    .res_rt_data(res_rt_data),
    .res_rs_num (res_rs_num),
    .res_rs_data(res_rs_data)
);

// File: tb/sim_wide_muladd_unit.sv
module sim_wide_muladd_unit;
    localparam logic [5:0] PO = 6'd4;
    localparam logic [5:0] XO = 6'd48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_insn = '0;
    logic        in_rs_from_rc = 1'b0;
    logic [6:0]  in_maxvl = '0;
    logic [63:0] in_a = '0, in_b = '0, in_c = '0;
    logic        res_valid;
    logic        res_ready = 1'b1;
    logic        res_illegal, res_wr_en;
    logic [6:0]  res_rt_num, res_rs_num;
    logic [63:0] res_rt_data, res_rs_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    wide_muladd_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .in_rs_from_rc(in_rs_from_rc), .in_maxvl(in_maxvl),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .res_valid(res_valid),
        .res_ready(res_ready), .res_illegal(res_illegal), .res_wr_en(res_wr_en),
        .res_rt_num(res_rt_num), .res_rt_data(res_rt_data),
        .res_rs_num(res_rs_num), .res_rs_data(res_rs_data)
    );

    always #5 clk = ~clk;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [5:0] po, logic [4:0] rt, logic [4:0] ra,
                                       logic [4:0] rb, logic [4:0] rc, logic [5:0] xo);
        return {po, rt, ra, rb, rc, xo};
    endfunction

    // Offer one op, follow it to the output, and check latency and fields (R8).
    task automatic run_op(string req, logic [31:0] insn, logic mode, logic [6:0] mvl,
                          logic [63:0] a, logic [63:0] b, logic [63:0] c, logic ill,
                          logic [6:0] exp_rt, logic [6:0] exp_rs);
        logic [127:0] full;
        full = {64'd0, a} * {64'd0, b} + {64'd0, c};
        if (ill) full = '0;
        @(negedge clk);
        in_valid = 1'b1; in_insn = insn; in_rs_from_rc = mode; in_maxvl = mvl;
        in_a = a; in_b = b; in_c = c;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "valid after 1 edge", 64'(res_valid), 64'd0);
        @(posedge clk);
        @(negedge clk);
        check("R8", "valid after 2 edges", 64'(res_valid), 64'd0);
        @(posedge clk);
        @(negedge clk);
        check("R8", "valid after 3 edges", 64'(res_valid), 64'd1);
        check("R7", "illegal flag", 64'(res_illegal), 64'(ill));
        check("R7", "write enable", 64'(res_wr_en), 64'(!ill));
        check(req, "rt number", 64'(res_rt_num), 64'(exp_rt));
        check(req, "rs number", 64'(res_rs_num), 64'(exp_rs));
        check(req, "low half", res_rt_data, full[63:0]);
        check(req, "high half", res_rs_data, full[127:64]);
        @(posedge clk);
        @(negedge clk);
        check("R8", "valid drops", 64'(res_valid), 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10", "valid in reset", 64'(res_valid), 64'd0);
        check("R10", "ready in reset", 64'(in_ready), 64'd1);
    endtask

    task automatic t_small();  // R1 R2 R6
        run_op("R2", mk(PO, 5'd4, 5'd1, 5'd2, 5'd9, XO), 1'b1, 7'd0,
               64'd3, 64'd5, 64'd7, 1'b0, 7'd4, 7'd9);
        run_op("R1", mk(PO, 5'd17, 5'd30, 5'd29, 5'd3, XO), 1'b1, 7'd5,
               64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321, 64'd11, 1'b0, 7'd17, 7'd3);
    endtask

    task automatic t_max();  // R3 R5
        run_op("R3", mk(PO, 5'd31, 5'd0, 5'd0, 5'd2, XO), 1'b0, 7'd16,
               '1, '1, '1, 1'b0, 7'd31, 7'd47);
    endtask

    task automatic t_wrap();  // R5
        run_op("R5", mk(PO, 5'd31, 5'd1, 5'd1, 5'd1, XO), 1'b0, 7'd120,
               64'd9, 64'd9, 64'd0, 1'b0, 7'd31, 7'd23);
    endtask

    task automatic t_carry();  // R4
        run_op("R4", mk(PO, 5'd2, 5'd3, 5'd4, 5'd5, XO), 1'b1, 7'd0,
               64'h8000_0000_0000_0000, 64'd2, '1, 1'b0, 7'd2, 7'd5);
        run_op("R4", mk(PO, 5'd6, 5'd3, 5'd4, 5'd8, XO), 1'b0, 7'd1,
               64'hffff_ffff_0000_0001, 64'h0000_0001_ffff_ffff, 64'hdead_beef, 1'b0, 7'd6, 7'd7);
    endtask

    task automatic t_illegal();  // R7
        run_op("R7", mk(6'd5, 5'd1, 5'd1, 5'd1, 5'd1, XO), 1'b1, 7'd0,
               64'd3, 64'd3, 64'd3, 1'b1, 7'd1, 7'd1);
        run_op("R7", mk(PO, 5'd1, 5'd1, 5'd1, 5'd2, 6'd49), 1'b1, 7'd0,
               64'd3, 64'd3, 64'd3, 1'b1, 7'd1, 7'd2);
    endtask

    task automatic t_stall();  // R9
        logic [127:0] full;
        full = 128'd1000 * 128'd1000 + 128'd1;
        res_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_insn = mk(PO, 5'd8, 5'd0, 5'd0, 5'd9, XO); in_rs_from_rc = 1'b0;
        in_maxvl = 7'd2; in_a = 64'd1000; in_b = 64'd1000; in_c = 64'd1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9", "valid under stall", 64'(res_valid), 64'd1);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R9", "in_ready under stall", 64'(in_ready), 64'd0);
            check("R9", "held low half", res_rt_data, full[63:0]);
            check("R9", "held rs number", 64'(res_rs_num), 64'd10);
        end
        res_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9", "released", 64'(res_valid), 64'd0);
        check("R9", "ready again", 64'(in_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_small();
        t_max();
        t_wrap();
        t_carry();
        t_illegal();
        t_stall();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule